// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block listens to the clock and data wires of a two-wire serial bus without ever driving them. Each wire first passes through a synchronizer and a glitch filter whose hold length is set at run time. The cleaned pair is then decoded into bus events: a pulse for a START on a free bus, a separate pulse for a START on a bus that is already busy (a repeated START), and a pulse for a STOP. The block also gives a level showing whether the bus is busy, plus a strobe on every clock rise inside a transfer, together with the sampled data level and the bit's position within its frame.

Neighbouring logic, such as an address matcher or a bus-error counter, uses these pulses as its only view of the wires. A further pulse marks a data edge during the clock-high phase that lands deep inside a frame. A legal stop or restart never lands there, so such an edge points to an aborted or corrupted transfer. All outputs are single-cycle pulses or plain levels. Nothing is handshaked, so the consumer must take each pulse in the cycle it appears.

Top module: `i2c_bus_watch`

## Requirements
- R1: After reset the bus reads as free (`bus_busy` low), `bit_index` is 0 and no event pulse or strobe is high.
- R2: A falling data edge while the filtered clock is high, on a free bus, gives exactly one `start_pulse`, and `bus_busy` is high from the next cycle.
- R3: A rising data edge while the filtered clock is high, on a busy bus, gives exactly one `stop_pulse`, and `bus_busy` is low from the next cycle.
- R4: A falling data edge while the clock is high, on a busy bus, gives `rstart_pulse` and no `start_pulse`. `bus_busy` stays high and the bit position restarts at 0.
- R5: A rising data edge while the clock is high, on a free bus, is ignored: no `stop_pulse`, and `bus_busy` stays low.
- R6: `bit_strobe` pulses once for each filtered clock rise while the bus is busy, and never while it is free. In that cycle `bit_value` equals the filtered data level.
- R7: In a strobe cycle, `bit_index` gives the number of strobes since the last START, repeated START, STOP or wrap. The values run 0 to 8, and the count goes back to 0 after the strobe that carries 8.
- R8: `sda_err` pulses when the data wire changes while the clock is high on a busy bus and `bit_index` is 2 or more. The START, repeated START or STOP that the edge forms still takes effect.
- R9: A wire's filtered level changes only after the synchronized input has held the new level for max(`cfg_hold`,1) consecutive clocks. A shorter excursion has no effect.
- R10: No two of `start_pulse`, `rstart_pulse` and `stop_pulse` are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hold | input | FILT_W (4) | Clocks a new input level must persist before it is accepted (0 acts as 1) |
| scl_in | input | 1 | Raw bus clock wire |
| sda_in | input | 1 | Raw bus data wire |
| start_pulse | output | 1 | START seen on a free bus |
| rstart_pulse | output | 1 | START seen on a busy bus |
| stop_pulse | output | 1 | STOP seen on a busy bus |
| bus_busy | output | 1 | High between START and STOP |
| bit_strobe | output | 1 | Clock rise while busy |
| bit_value | output | 1 | Filtered data level, valid with `bit_strobe` |
| bit_index | output | 4 | Bit position within the frame, 0 to 8 |
| sda_err | output | 1 | Data edge in the clock-high phase deep in a frame |

## Verification
The properties take for granted that the two wires never change in the same filtered cycle, and that each level is held well beyond the filter length. Under those conditions every data edge during the clock-high phase is unambiguous. The stimulus keeps to this by holding every wire level for sixteen clocks while `cfg_hold` is at most eight. The only exception is the directed filter cases, which send deliberately short excursions on the data wire while the clock sits high. Random transfers vary the byte count, data, acknowledge level, mid-transfer restarts and mid-byte aborts.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;
  localparam int IDX_W    = 4;
  localparam int LAST_BIT = 8;
  localparam int ERR_FROM = 2;

  typedef logic [IDX_W-1:0] bit_idx_t;

  typedef struct packed {
    logic scl;
    logic sda;
  } line_pair_t;
endpackage

// File: rtl/iw_line_filter.sv
module iw_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] hold_cfg,
  input  logic             raw_in,
  output logic             clean_out
);
  localparam int CMP_W = CNT_W + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       run_q;
  logic                   level_q;
  logic [CNT_W-1:0]       need_n;
  logic [CMP_W-1:0]       run_next;
  logic                   synced;

  assign synced   = sync_q[SYNC_STAGES-1];
  assign need_n   = (hold_cfg == '0) ? CNT_W'(1) : hold_cfg;
  assign run_next = {1'b0, run_q} + CMP_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      run_q   <= '0;
    end else if (synced == level_q) begin
      run_q <= '0;
    end else if (run_next >= {1'b0, need_n}) begin
      level_q <= synced;
      run_q   <= '0;
    end else begin
      run_q <= run_next[CNT_W-1:0];
    end
  end

  assign clean_out = level_q;
endmodule

// File: rtl/iw_edge_decode.sv
module iw_edge_decode
  import i2c_watch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  line_pair_t lines,
  input  bit_idx_t   frame_pos,
  output logic       start_seen,
  output logic       stop_seen,
  output logic       clk_rise,
  output logic       start_pulse,
  output logic       rstart_pulse,
  output logic       stop_pulse,
  output logic       busy,
  output logic       sda_err
);
  line_pair_t prev_q;
  logic       busy_q;
  logic       scl_high, sda_fall, sda_rise;

  assign scl_high = lines.scl & prev_q.scl;
  assign sda_fall = prev_q.sda & ~lines.sda;
  assign sda_rise = ~prev_q.sda & lines.sda;

  assign start_seen   = scl_high & sda_fall;
  assign stop_seen    = scl_high & sda_rise;
  assign clk_rise     = lines.scl & ~prev_q.scl;
  assign start_pulse  = start_seen & ~busy_q;
  assign rstart_pulse = start_seen & busy_q;
  assign stop_pulse   = stop_seen & busy_q;
  assign sda_err      = busy_q & (start_seen | stop_seen) &
                        (frame_pos >= bit_idx_t'(ERR_FROM));
  assign busy         = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '{scl: 1'b1, sda: 1'b1};
      busy_q <= 1'b0;
    end else begin
      prev_q <= lines;
      if (start_seen) begin
        busy_q <= 1'b1;
      end else if (stop_seen) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/iw_bit_counter.sv
module iw_bit_counter
  import i2c_watch_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frame_clear,
  input  logic     step,
  output bit_idx_t pos
);
  bit_idx_t pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (frame_clear) begin
      pos_q <= '0;
    end else if (step) begin
      pos_q <= (pos_q == bit_idx_t'(LAST_BIT)) ? '0 : pos_q + bit_idx_t'(1);
    end
  end

  assign pos = pos_q;
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
  import i2c_watch_pkg::*;
#(
  parameter int FILT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILT_W-1:0] cfg_hold,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              start_pulse,
  output logic              rstart_pulse,
  output logic              stop_pulse,
  output logic              bus_busy,
  output logic              bit_strobe,
  output logic              bit_value,
  output logic [IDX_W-1:0]  bit_index,
  output logic              sda_err
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_v;
  logic [N_LINES-1:0] clean_v;
  line_pair_t         clean;
  bit_idx_t           pos;
  logic               start_seen, stop_seen, clk_rise;

  assign raw_v = {scl_in, sda_in};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    iw_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .CNT_W      (FILT_W)
    ) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_cfg (cfg_hold),
      .raw_in   (raw_v[g]),
      .clean_out(clean_v[g])
    );
  end

  assign clean = line_pair_t'(clean_v);

  iw_edge_decode u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .lines       (clean),
    .frame_pos   (pos),
    .start_seen  (start_seen),
    .stop_seen   (stop_seen),
    .clk_rise    (clk_rise),
    .start_pulse (start_pulse),
    .rstart_pulse(rstart_pulse),
    .stop_pulse  (stop_pulse),
    .busy        (bus_busy),
    .sda_err     (sda_err)
  );

  assign bit_strobe = clk_rise & bus_busy;
  assign bit_value  = clean.sda;

  iw_bit_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_clear(start_seen | stop_seen),
    .step       (bit_strobe),
    .pos        (pos)
  );

  assign bit_index = pos;
endmodule

// File: rtl/iw_watch_chk.sv
module iw_watch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_pulse,
  input logic       rstart_pulse,
  input logic       stop_pulse,
  input logic       bus_busy,
  input logic       bit_strobe,
  input logic [3:0] bit_index,
  input logic       sda_err
);
  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !bus_busy ##1 bus_busy);
  // R3
  stop_frees_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !bus_busy);
  // R4
  rstart_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_pulse |-> bus_busy ##1 bus_busy);
  // R5
  stop_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> bus_busy);
  // R3
  busy_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> $past(stop_pulse));
  // R6
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> bus_busy);
  // R7
  index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_index <= 4'd8);
  // R8
  err_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_err |-> (bus_busy && bit_index >= 4'd2 && (rstart_pulse || stop_pulse)));
  // R10
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, rstart_pulse, stop_pulse}));
endmodule

bind i2c_bus_watch iw_watch_chk u_watch_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_pulse (start_pulse),
  .rstart_pulse(rstart_pulse),
  .stop_pulse  (stop_pulse),
  .bus_busy    (bus_busy),
  .bit_strobe  (bit_strobe),
  .bit_index   (bit_index),
  .sda_err     (sda_err)
);

// File: tb/i2c_bus_watch_bench.sv
module i2c_bus_watch_bench;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_hold = 4'd4;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic       start_pulse, rstart_pulse, stop_pulse, bus_busy;
  logic       bit_strobe, bit_value, sda_err;
  logic [3:0] bit_index;

  always #5 clk = ~clk;

  i2c_bus_watch u_i2c_bus_watch (
    .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold),
    .scl_in(scl), .sda_in(sda),
    .start_pulse(start_pulse), .rstart_pulse(rstart_pulse),
    .stop_pulse(stop_pulse), .bus_busy(bus_busy),
    .bit_strobe(bit_strobe), .bit_value(bit_value),
    .bit_index(bit_index), .sda_err(sda_err)
  );

  int checks = 0, errors = 0;
  int n_start = 0, n_rstart = 0, n_stop = 0, n_err = 0;
  int e_start = 0, e_rstart = 0, e_stop = 0, e_err = 0;
  int exp_val[256];
  int exp_idx[256];
  int wp = 0, rp = 0;
  bit m_busy = 0;
  int m_idx = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int next_idx(input int i);
    return (i == 8) ? 0 : i + 1;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_pulse)  n_start++;
      if (rstart_pulse) n_rstart++;
      if (stop_pulse)   n_stop++;
      if (sda_err)      n_err++;
      if (bit_strobe) begin
        if (rp < wp) begin
          chk(bit_value == exp_val[rp % 256][0], "R6", "bit value", int'(bit_value), exp_val[rp % 256]);
          chk(int'(bit_index) == exp_idx[rp % 256], "R7", "bit index", int'(bit_index), exp_idx[rp % 256]);
        end else begin
          chk(1'b0, "R6", "unexpected strobe", 1, 0);
        end
        rp++;
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_scl(input bit v);
    if (v && !scl && m_busy) begin
      exp_val[wp % 256] = int'(sda);
      exp_idx[wp % 256] = m_idx;
      wp++;
      m_idx = next_idx(m_idx);
    end
    scl = v;
    hold(Q);
  endtask

  task automatic set_sda(input bit v);
    if (scl && v != sda) begin
      if (m_busy && m_idx >= 2) e_err++;
      if (!v) begin
        if (m_busy) e_rstart++; else e_start++;
        m_busy = 1;
      end else begin
        if (m_busy) e_stop++;
        m_busy = 0;
      end
      m_idx = 0;
    end
    sda = v;
    hold(Q);
  endtask

  task automatic do_start();
    set_sda(1'b1); set_scl(1'b1); set_sda(1'b0); set_scl(1'b0);
  endtask

  task automatic do_stop();
    set_sda(1'b0); set_scl(1'b1); set_sda(1'b1);
  endtask

  task automatic send_bit(input bit b);
    set_sda(b); set_scl(1'b1); hold(Q); set_scl(1'b0);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    send_bit(ack);
  endtask

  task automatic compare_counts();
    chk(n_start == e_start, "R2", "start count", n_start, e_start);
    chk(n_rstart == e_rstart, "R4", "repeated start count", n_rstart, e_rstart);
    chk(n_stop == e_stop, "R3", "stop count", n_stop, e_stop);
    chk(n_err == e_err, "R8", "error count", n_err, e_err);
    chk(rp == wp, "R6", "strobe count", rp, wp);
  endtask

  initial begin
    hold(150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    hold(3);
    rst_n = 1'b1;
    hold(Q);
    // R1 reset state
    chk(bus_busy == 1'b0, "R1", "busy after reset", int'(bus_busy), 0);
    chk(bit_index == 4'd0, "R1", "index after reset", int'(bit_index), 0);
    chk(n_start + n_rstart + n_stop + rp == 0, "R1", "pulses after reset", n_start + n_rstart + n_stop + rp, 0);

    // R2 R3 plain write of two bytes
    do_start();
    chk(bus_busy == 1'b1, "R2", "busy after start", int'(bus_busy), 1);
    send_byte(8'hA4, 1'b0);
    send_byte(8'h5B, 1'b0);
    do_stop();
    chk(bus_busy == 1'b0, "R3", "busy after stop", int'(bus_busy), 0);
    compare_counts();

    // R4 repeated start in a combined transfer
    do_start();
    send_byte(8'h3C, 1'b0);
    do_start();
    chk(bus_busy == 1'b1, "R4", "busy after repeated start", int'(bus_busy), 1);
    chk(bit_index == 4'd0, "R4", "index after repeated start", int'(bit_index), 0);
    send_byte(8'hF1, 1'b1);
    do_stop();
    compare_counts();

    // R5 stop on a free bus is ignored
    set_scl(1'b0); set_sda(1'b0); set_scl(1'b1); set_sda(1'b1);
    chk(bus_busy == 1'b0, "R5", "busy after idle stop", int'(bus_busy), 0);
    chk(n_stop == e_stop, "R5", "idle stop pulses", n_stop, e_stop);
    compare_counts();

    // R8 abort after three bits, and repeated start mid byte
    do_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    do_stop();
    do_start();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    do_start();
    send_byte(8'h81, 1'b0);
    do_stop();
    compare_counts();

    // R9 filter boundary: 5 clocks rejected, 6 accepted at hold 6
    cfg_hold = 4'd6;
    hold(Q);
    sda = 1'b0; hold(5); sda = 1'b1; hold(2 * Q);
    chk(n_start == e_start && bus_busy == 1'b0, "R9", "short pulse rejected", n_start, e_start);
    sda = 1'b0; hold(6); sda = 1'b1; hold(2 * Q);
    e_start++; e_stop++;
    chk(n_start == e_start, "R9", "held pulse start", n_start, e_start);
    chk(n_stop == e_stop, "R9", "held pulse stop", n_stop, e_stop);
    // R9 a hold of zero acts as one
    cfg_hold = 4'd0;
    sda = 1'b0; hold(1); sda = 1'b1; hold(2 * Q);
    e_start++; e_stop++;
    chk(n_start == e_start, "R9", "zero hold start", n_start, e_start);
    chk(n_stop == e_stop, "R9", "zero hold stop", n_stop, e_stop);
    compare_counts();

    // random transfers
    for (int t = 0; t < 30; t++) begin
      int nb;
      cfg_hold = 4'($urandom_range(1, 8));
      nb = $urandom_range(1, 3);
      do_start();
      for (int b = 0; b < nb; b++) begin
        if ($urandom_range(0, 9) < 3) do_start();
        if ($urandom_range(0, 9) < 2) begin
          int k;
          k = $urandom_range(1, 7);
          for (int j = 0; j < k; j++) send_bit(1'($urandom_range(0, 1)));
        end else begin
          send_byte(8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
        end
      end
      do_stop();
      compare_counts();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule